// File: doc/BRIEF.md
# Scaled E2M1 Nibble Quantizer

This block turns one single-precision element and its positive block scale into a 4-bit E2M1 code. It forms the quotient of element over scale. It rounds twice the clamped quotient magnitude to the nearest integer, with ties going to the even neighbour. A twelve-entry table then maps that doubled magnitude onto one of eight representable levels. The result is a nibble that holds the level index in its low three bits and the sign of the quotient in its top bit.

The quotient comes from a bit-serial restoring divider that works on the two significands, with one quotient bit per clock. A start pulse loads the operands and raises busy. When the nibble is ready, done pulses high for a single cycle. Operand pairs whose result is already fixed by their exponents skip the divider. So do invalid scales and zero elements.

Top module: `e2m1_quant`

## Requirements
- R1: If the scale is not strictly greater than the single-precision number nearest to 1e-8 (encoding 0x322BCC77), the nibble is 0x0 whatever the element is. This includes zero and negative scales.
- R2: Quotient magnitudes of 6.0 and above give index 7, including quotients far beyond the single-precision range of the element.
- R3: The doubled magnitude 2·min(|q|, 6) is rounded to the nearest integer, and an exact tie goes to the even integer. The divider keeps enough bits that this rounding matches the exact quotient.
- R4: The rounded doubled magnitude h selects the index as follows: 0→0, 1→1, 2→2, 3→3, 4 and 5→4, 6→5, 7 to 9→6, and 10 or more→7.
- R5: Bits [2:0] of the nibble hold the index. Indices 0 through 7 stand for the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4 and 6.
- R6: Bit 3 of the nibble is 1 exactly when the quotient is strictly negative. This holds even when the index is 0, for example for a tiny or subnormal negative element.
- R7: An element of +0.0 or -0.0 gives the nibble 0x0.
- R8: done is high for exactly one cycle per accepted start, and the nibble is valid in that cycle. The nibble changes only in a cycle where done is high, and otherwise holds its value.
- R9: A start pulse that arrives while busy is high is ignored. The running operation completes with its own result, and no extra done follows.
- R10: busy rises in the cycle after an accepted start and stays high until the cycle in which done is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to quantize the presented operands |
| value | input | 32 | Element to quantize, single precision |
| scale | input | 32 | Block scale, single precision |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: nibble holds a fresh result |
| nibble | output | 4 | Sign in bit 3, level index in bits [2:0] |

## Verification
Random element and scale pairs use exponents within a few binades of each other, so every level and both signs show up. Against these, a bench model computes the rounding from the exact quotient. Directed pairs with a power-of-two scale put the doubled magnitude exactly on .5 ties and on the table entries that merge, which separates ties-to-even from round-half-up and shows each table row. Scales at the threshold and just above it, signed zeros, a negative subnormal and extreme exponent ratios exercise the short-cut paths. A second start injected mid-division shows that the first operands win.

// File: rtl/e2m1_quant_pkg.sv
package e2m1_quant_pkg;

  // strobes from sequencing control to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear divider
    logic step;    // one restoring division step
    logic finish;  // round, look up, register nibble
  } quantStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } quantState_t;

endpackage

// File: rtl/e2m1_quant_ctrl.sv
module e2m1_quant_ctrl
  import e2m1_quant_pkg::*;
#(
  parameter int STEPS = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         quick,
  output quantStrobe_t strobe,
  output logic         busy,
  output logic         done
);

  localparam int CNT_W = $clog2(STEPS + 1);

  quantState_t state;
  logic [CNT_W-1:0] stepsLeft;

  always_comb begin
    strobe        = '0;
    strobe.load   = (state == ST_IDLE) && start;
    strobe.step   = (state == ST_RUN);
    strobe.finish = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepsLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= strobe.finish;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= quick ? ST_FIN : ST_RUN;
            stepsLeft <= CNT_W'(STEPS);
          end
        end
        ST_RUN: begin
          stepsLeft <= stepsLeft - 1'b1;
          if (stepsLeft == CNT_W'(1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/e2m1_quant_dp.sv
module e2m1_quant_dp
  import e2m1_quant_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 24,
  parameter int WORD_W = EXP_W + MANT_W,
  parameter logic [WORD_W-1:0] SCALE_MIN = 32'h322BCC77
) (
  input  logic              clk,
  input  logic              rstN,
  input  quantStrobe_t      strobe,
  input  logic [WORD_W-1:0] value,
  input  logic [WORD_W-1:0] scale,
  output logic              quick,
  output logic [3:0]        nibble
);

  localparam int FRAC_W = MANT_W - 1;
  localparam int QUO_W  = 2 * MANT_W;
  localparam int G_W    = 5;               // floor(4|q|) below saturation
  localparam int WIDE_W = QUO_W + G_W;
  localparam int E_W    = EXP_W + 3;
  localparam logic signed [E_W-1:0] SAT_LIM  = E_W'(MANT_W + 5);
  localparam logic signed [E_W-1:0] ZERO_LIM = -E_W'(MANT_W + 1);
  localparam logic signed [E_W-1:0] MID_E    = E_W'(MANT_W);

  // operand decode
  logic [EXP_W-1:0]  vExp, sExp, vExpEff, sExpEff;
  logic [MANT_W-1:0] vMant, sMant;
  logic              scaleOk, valZero, satIn, zeroIn;
  logic signed [E_W-1:0] eIn;

  assign vExp    = value[WORD_W-2 -: EXP_W];
  assign sExp    = scale[WORD_W-2 -: EXP_W];
  assign vExpEff = (vExp == '0) ? EXP_W'(1) : vExp;
  assign sExpEff = (sExp == '0) ? EXP_W'(1) : sExp;
  assign vMant   = {|vExp, value[FRAC_W-1:0]};
  assign sMant   = {|sExp, scale[FRAC_W-1:0]};
  assign scaleOk = !scale[WORD_W-1] && (scale[WORD_W-2:0] > SCALE_MIN[WORD_W-2:0]);
  assign valZero = (vMant == '0);
  // exponent of 4|q| relative to the significand ratio
  assign eIn     = E_W'(vExpEff) - E_W'(sExpEff) + E_W'(2);
  assign zeroIn  = !scaleOk || valZero || (eIn <= ZERO_LIM);
  assign satIn   = !zeroIn && (eIn >= SAT_LIM);
  assign quick   = zeroIn || satIn;

  // divider state
  logic              negQ, forceZero, forceSat;
  logic signed [E_W-1:0] eReg;
  logic [MANT_W-1:0] divisor, rem;
  logic [QUO_W-1:0]  numer, quo;
  logic [MANT_W:0]   trial, trialDiff;
  logic              fits;

  assign trial     = {rem, numer[QUO_W-1]};
  assign trialDiff = trial - {1'b0, divisor};
  assign fits      = (trial >= {1'b0, divisor});

  // rounding and lookup
  logic [WIDE_W-1:0] wide;
  logic [E_W-1:0]    upSh, dnSh;
  logic              lowLost, over, sticky, roundUp;
  logic [G_W-1:0]    halfStep;
  logic [2:0]        idx;

  function automatic logic [2:0] levelOf(input logic [G_W-1:0] hs);
    case (hs)
      5'd0:          levelOf = 3'd0;
      5'd1:          levelOf = 3'd1;
      5'd2:          levelOf = 3'd2;
      5'd3:          levelOf = 3'd3;
      5'd4, 5'd5:    levelOf = 3'd4;
      5'd6:          levelOf = 3'd5;
      5'd7, 5'd8,
      5'd9:          levelOf = 3'd6;
      default:       levelOf = 3'd7;
    endcase
  endfunction

  always_comb begin
    upSh    = eReg - MID_E;
    dnSh    = MID_E - eReg;
    wide    = '0;
    lowLost = 1'b0;
    if (eReg >= MID_E) begin
      wide = {{G_W{1'b0}}, quo} << upSh;
    end else begin
      wide    = {{G_W{1'b0}}, quo >> dnSh};
      lowLost = |(quo & ~({QUO_W{1'b1}} << dnSh));
    end
    over     = |wide[WIDE_W-1:G_W];
    sticky   = lowLost || (rem != '0);
    roundUp  = wide[0] && (sticky || wide[1]);
    halfStep = {1'b0, wide[G_W-1:1]} + G_W'(roundUp);
    if (forceZero)                idx = 3'd0;
    else if (forceSat || over)    idx = 3'd7;
    else                          idx = levelOf(halfStep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negQ      <= 1'b0;
      forceZero <= 1'b1;
      forceSat  <= 1'b0;
      eReg      <= '0;
      divisor   <= '0;
      rem       <= '0;
      numer     <= '0;
      quo       <= '0;
      nibble    <= '0;
    end else begin
      if (strobe.load) begin
        negQ      <= scaleOk && !valZero && value[WORD_W-1];
        forceZero <= zeroIn;
        forceSat  <= satIn;
        eReg      <= eIn;
        divisor   <= sMant;
        rem       <= '0;
        numer     <= {vMant, MANT_W'(0)};
        quo       <= '0;
      end
      if (strobe.step) begin
        rem   <= fits ? trialDiff[MANT_W-1:0] : trial[MANT_W-1:0];
        quo   <= {quo[QUO_W-2:0], fits};
        numer <= {numer[QUO_W-2:0], 1'b0};
      end
      if (strobe.finish) nibble <= {negQ, idx};
    end
  end

endmodule

// File: rtl/e2m1_quant.sv
module e2m1_quant
  import e2m1_quant_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 24,
  parameter int WORD_W = EXP_W + MANT_W,
  parameter logic [WORD_W-1:0] SCALE_MIN = 32'h322BCC77
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] value,
  input  logic [WORD_W-1:0] scale,
  output logic              busy,
  output logic              done,
  output logic [3:0]        nibble
);

  localparam int STEPS = 2 * MANT_W;

  quantStrobe_t strobe;
  logic         quick;

  e2m1_quant_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .quick  (quick),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  e2m1_quant_dp #(
    .EXP_W     (EXP_W),
    .MANT_W    (MANT_W),
    .WORD_W    (WORD_W),
    .SCALE_MIN (SCALE_MIN)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .value  (value),
    .scale  (scale),
    .quick  (quick),
    .nibble (nibble)
  );

endmodule

// File: rtl/e2m1_quant_chk.sv
module e2m1_quant_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [3:0] nibble
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_nibble_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nibble) |-> done);

  assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_ends_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> (busy || done));

endmodule

bind e2m1_quant e2m1_quant_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .nibble (nibble)
);

// File: tb/e2m1_quant_bench.sv
module e2m1_quant_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] value = '0;
  logic [31:0] scale = '0;
  logic        busy, done;
  logic [3:0]  nibble;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  e2m1_quant u_e2m1_quant (
    .clk(clk), .rstN(rstN), .start(start), .value(value), .scale(scale),
    .busy(busy), .done(done), .nibble(nibble)
  );

  function automatic real toReal(input logic [31:0] b);
    real mag;
    int  ex;
    ex = int'(b[30:23]);
    if (ex == 0) mag = real'(b[22:0]) * (2.0 ** (-149.0));
    else         mag = (real'(b[22:0]) + 8388608.0) * (2.0 ** real'(ex - 150));
    return b[31] ? -mag : mag;
  endfunction

  function automatic logic [3:0] model(input logic [31:0] v, input logic [31:0] s);
    real sr, q, a, h, fl;
    int  hs;
    logic [2:0] ix;
    sr = toReal(s);
    if (!(sr > 1.0e-8)) return 4'h0;
    q = toReal(v) / sr;
    a = (q < 0.0) ? -q : q;
    if (a > 6.0) a = 6.0;
    h  = a * 2.0;
    fl = $floor(h);
    hs = int'(fl);
    if ((h - fl > 0.5) || ((h - fl == 0.5) && (hs % 2 == 1))) hs++;
    if (hs > 11) hs = 11;
    case (hs)
      0: ix = 0; 1: ix = 1; 2: ix = 2; 3: ix = 3; 4, 5: ix = 4;
      6: ix = 5; 7, 8, 9: ix = 6; default: ix = 7;
    endcase
    return {q < 0.0, ix};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!done) check({req, " timeout"}, 32'd0, 32'd1);
  endtask

  // one operation; checks busy, nibble and the single-cycle done
  task automatic runOp(input string req, input logic [31:0] v, input logic [31:0] s);
    @(negedge clk);
    value = v; scale = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", busy, 1);
    waitDone(req);
    check(req, nibble, model(v, s));
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R8 nibble held", nibble, model(v, s));
  endtask

  localparam logic [31:0] ONE = 32'h3F800000;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("reset nibble", nibble, 0);
    check("reset busy", busy, 0);
    check("reset done", done, 0);
    rstN = 1'b1;

    // R1 scale gating
    runOp("R1 scale at threshold", 32'h40000000, 32'h322BCC77);
    runOp("R1 scale just above", 32'h322BCC78, 32'h322BCC78);
    runOp("R1 zero scale", 32'hC0000000, 32'h00000000);
    runOp("R1 negative scale", 32'hC0000000, 32'hBF800000);
    // R2 saturation
    runOp("R2 exactly six", 32'h40C00000, ONE);
    runOp("R2 huge ratio", 32'h7F7FFFFF, 32'h322BCC78);
    runOp("R2 huge negative", 32'hFF7FFFFF, 32'h322BCC78);
    // R3 ties to even (scale 1): 0.25 0.75 1.25 1.75 4.25 4.75 5.25
    runOp("R3 tie h=0.5", 32'h3E800000, ONE);
    runOp("R3 tie h=1.5", 32'h3F400000, ONE);
    runOp("R3 tie h=2.5", 32'h3FA00000, ONE);
    runOp("R3 tie h=3.5", 32'h3FE00000, ONE);
    runOp("R3 tie h=8.5", 32'h40880000, ONE);
    runOp("R3 tie h=9.5", 32'h40980000, ONE);
    runOp("R3 tie h=10.5", 32'h40A80000, ONE);
    // R4/R5 each doubled magnitude 0..11 with scale 2
    for (int k = 0; k <= 11; k++) begin
      real  target;
      shortreal sv;
      target = real'(k) * 0.5 * 2.0;
      sv = shortreal'(target);
      runOp("R4 R5 table row", $shortrealtobits(sv), 32'h40000000);
    end
    // R6 negative tiny, negative subnormal
    runOp("R6 negative tiny", 32'hBA800000, ONE);
    runOp("R6 negative subnormal", 32'h80000001, ONE);
    runOp("R6 negative mid", 32'hC0400000, ONE);
    // R7 signed zeros
    runOp("R7 plus zero", 32'h00000000, ONE);
    runOp("R7 minus zero", 32'h80000000, ONE);

    // R9 start while busy is ignored
    begin
      logic [3:0] expA;
      expA = model(32'h40400000, ONE);
      @(negedge clk);
      value = 32'h40400000; scale = ONE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      value = 32'hC0C00000; scale = ONE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitDone("R9");
      check("R9 first operands win", nibble, expA);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (done) check("R9 no extra done", done, 0);
      end
      check("R9 idle after", busy, 0);
    end

    // random pairs with nearby exponents
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  se;
      logic [31:0] s, v;
      se = 8'(100 + $urandom % 60);
      s  = {1'b0, se, 23'($urandom)};
      v  = {1'($urandom), 8'(int'(se) - 6 + int'($urandom % 10)), 23'($urandom)};
      if (i % 4 == 0) v[18:0] = '0;
      if (i % 8 == 0) s[22:0] = '0;
      runOp("R3 R4 R6 random", v, s);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule